// File: doc/BRIEF.md
# Gated Pulse Accumulator Timer

This block is an 8-bit accumulator that measures how long an external gate signal stays active. A free-running clock is divided by 64 inside the block to form a count tick, and the counter advances by one on each tick only while the gate sits at its active level. When the counter rolls over from its maximum value to zero, a sticky overflow flag is raised. A mask bit can route that flag to an interrupt request. Software builds long intervals by preloading the counter so that it overflows after a chosen number of ticks, and by counting the overflows.

A control register turns the block on and chooses between the gated-time mode and an event mode. In event mode each qualifying edge of the gate input advances the counter directly, with no prescaling. A polarity bit selects which gate level inhibits counting in gated mode, or which edge counts in event mode. Four registers sit behind a two-bit register select: control, count, flag and mask. Their selected value appears on a registered read port.

Top module: `gpa_timer`

## Requirements
- R1: After a synchronous reset, the control, count, flag and mask registers read 0, and ovf_o and irq_o are 0.
- R2: Control value 0x60 (enable is bit 6, gated mode is bit 5, polarity is bit 4 = 0) with the gate high advances the count by exactly one every 64 clocks.
- R3: In gated mode with polarity 0 a low gate holds the count. With polarity 1 (control 0x70) a low gate lets the count advance and a high gate holds it.
- R4: While bit 6 is 0 the count never changes except by a bus write. After enabling, the first tick lands a full 64 clocks after the control write, because the prescaler sits at zero while disabled.
- R5: A write to register select 1 loads the count. A preload of 6 in gated mode sets the overflow flag exactly 250 ticks (16000 clocks) after enabling.
- R6: An advance from 0xFF gives 0x00 and sets the overflow flag (bit 5 of register select 2) on that same clock. Counting then continues from 0x00.
- R7: Writing select 2 with bit 5 = 1 clears the overflow flag, and writing it with bit 5 = 0 leaves the flag unchanged. If a wrap falls in the same clock as the clearing write, the flag stays set.
- R8: ovf_o mirrors the overflow flag. irq_o is 1 exactly when the flag and the interrupt enable (bit 5 of register select 3) are both 1.
- R9: A count write in the same clock as a tick wins: the count takes the written value and that tick is lost.
- R10: Control 0x40 (event mode) advances the count once per rising gate edge, and control 0x50 advances it once per falling edge. The prescaler plays no part in this mode.
- R11: bus_rdata shows, one clock after bus_addr presents a select, the register behind it. Control reads only bits 6..4, and flag and mask read only bit 5. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 flag, 3 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data of the selected register |
| gate_in | input | 1 | External gate, synchronised inside |
| ovf_o | output | 1 | Registered sticky overflow flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check on every clock that the following hold:
- the counter stays still when disabled or when no increment is qualified;
- a count write wins over a tick;
- a wrap from 0xFF lands on zero and raises the flag;
- the flag stays set until a write with bit 5 = 1 clears it;
- the interrupt equals the flag gated by the mask.

Only the bench scenarios can show the 64-clock tick spacing, the full first period after enabling, the 250-tick interval for a preload of 6, the two gate polarities, and edge counting in event mode. Those checks depend on absolute cycle positions and on input histories that a single-cycle property does not capture.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  localparam int ADDR_W        = 2;
  localparam int CTL_EN_BIT    = 6;
  localparam int CTL_GATED_BIT = 5;
  localparam int CTL_POL_BIT   = 4;
  localparam int OVF_BIT       = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic gated;
    logic pol;
  } ctl_t;
endpackage

// File: rtl/gpa_prescaler.sv
module gpa_prescaler #(
  parameter int PRESC_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam logic [PRESC_W-1:0] LAST = {PRESC_W{1'b1}};
  logic [PRESC_W-1:0] presc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) presc_q <= '0;
    else             presc_q <= presc_q + 1'b1;
  end

  assign tick = run && (presc_q == LAST);
endmodule

// File: rtl/gpa_gate_cond.sv
module gpa_gate_cond (
  input  logic clk,
  input  logic rst,
  input  logic gate_in,
  input  logic en,
  input  logic gated,
  input  logic pol,
  input  logic presc_tick,
  output logic inc
);
  logic gate_s, gate_d;
  logic active, rise, fall, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_s <= 1'b0;
      gate_d <= 1'b0;
    end else begin
      gate_s <= gate_in;
      gate_d <= gate_s;
    end
  end

  always_comb begin
    active   = gate_s ^ pol;
    rise     = gate_s & ~gate_d;
    fall     = ~gate_s & gate_d;
    edge_hit = pol ? fall : rise;
    if (!en)        inc = 1'b0;
    else if (gated) inc = presc_tick & active;
    else            inc = edge_hit;
  end
endmodule

// File: rtl/gpa_counter.sv
module gpa_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap = inc && !load && (cnt_q == TOP);
endmodule

// File: rtl/gpa_regs.sv
module gpa_regs
  import gpa_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  wrap,
  input  logic [DATA_W-1:0]     cnt_q,
  output ctl_t                  ctl,
  output logic                  cnt_load,
  output logic                  ovf_q,
  output logic                  ien_q,
  output logic                  irq_q,
  output logic [DATA_W-1:0]     rdata_q
);
  logic ovf_n, ien_n;
  logic [DATA_W-1:0] rd_mux;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(addr);
  assign cnt_load = we && (sel == SEL_CNT);

  always_comb begin
    ovf_n = ovf_q;
    if (we && sel == SEL_FLAG && wdata[OVF_BIT]) ovf_n = 1'b0;
    if (wrap) ovf_n = 1'b1;
    ien_n = ien_q;
    if (we && sel == SEL_MASK) ien_n = wdata[OVF_BIT];
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[CTL_EN_BIT]    = ctl.en;
        rd_mux[CTL_GATED_BIT] = ctl.gated;
        rd_mux[CTL_POL_BIT]   = ctl.pol;
      end
      SEL_CNT:  rd_mux = cnt_q;
      SEL_FLAG: rd_mux[OVF_BIT] = ovf_q;
      default:  rd_mux[OVF_BIT] = ien_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      ovf_q   <= 1'b0;
      ien_q   <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (we && sel == SEL_CTRL) begin
        ctl.en    <= wdata[CTL_EN_BIT];
        ctl.gated <= wdata[CTL_GATED_BIT];
        ctl.pol   <= wdata[CTL_POL_BIT];
      end
      ovf_q   <= ovf_n;
      ien_q   <= ien_n;
      irq_q   <= ovf_n & ien_n;
      rdata_q <= rd_mux;
    end
  end
endmodule

// File: rtl/gpa_timer.sv
module gpa_timer
  import gpa_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PRESC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gate_in,
  output logic              ovf_o,
  output logic              irq_o
);
  ctl_t              ctl;
  logic              ctl_en;
  logic              presc_tick;
  logic              cnt_inc;
  logic              cnt_load;
  logic              cnt_wrap;
  logic [DATA_W-1:0] cnt_q;
  logic              ien_q;

  assign ctl_en = ctl.en;

  gpa_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .run  (ctl.en & ctl.gated),
    .tick (presc_tick)
  );

  gpa_gate_cond u_gate (
    .clk        (clk),
    .rst        (rst),
    .gate_in    (gate_in),
    .en         (ctl.en),
    .gated      (ctl.gated),
    .pol        (ctl.pol),
    .presc_tick (presc_tick),
    .inc        (cnt_inc)
  );

  gpa_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (bus_wdata),
    .inc      (cnt_inc),
    .cnt_q    (cnt_q),
    .wrap     (cnt_wrap)
  );

  gpa_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wrap     (cnt_wrap),
    .cnt_q    (cnt_q),
    .ctl      (ctl),
    .cnt_load (cnt_load),
    .ovf_q    (ovf_o),
    .ien_q    (ien_q),
    .irq_q    (irq_o),
    .rdata_q  (bus_rdata)
  );
endmodule

// File: rtl/gpa_timer_chk.sv
module gpa_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] cnt_q,
  input logic              cnt_inc,
  input logic              ctl_en,
  input logic              ien_q,
  input logic              ovf_o,
  input logic              irq_o
);
  logic wr_cnt, clr_flag;
  assign wr_cnt   = bus_we && (bus_addr == 2'd1);
  assign clr_flag = bus_we && (bus_addr == 2'd2) && bus_wdata[5];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && !ovf_o && !irq_o);

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !wr_cnt) |=> $stable(cnt_q));

  // R3
  no_inc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_inc && !wr_cnt) |=> $stable(cnt_q));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(bus_wdata)));

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && !wr_cnt && (cnt_q == {DATA_W{1'b1}})) |=> ((cnt_q == '0) && ovf_o));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr_flag) |=> ovf_o);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (ovf_o && ien_q));
endmodule

bind gpa_timer gpa_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt_q     (cnt_q),
  .cnt_inc   (cnt_inc),
  .ctl_en    (ctl_en),
  .ien_q     (ien_q),
  .ovf_o     (ovf_o),
  .irq_o     (irq_o)
);

// File: tb/gpa_timer_test.sv
module gpa_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       gate_in = 1'b0;
  logic       ovf_o, irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpa_timer uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_in(gate_in),
    .ovf_o(ovf_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Enable with ctl_val, then sweep the count every cycle against pre + elapsed ticks.
  task automatic sweep(input string req, input logic [7:0] pre, input logic [7:0] ctl_val,
                       input bit counting, input int n);
    wr(2'd0, 8'h00);
    wr(2'd1, pre);
    wr(2'd0, ctl_val);
    bus_addr = 2'd1;
    for (int k = 2; k <= n; k++) begin
      @(negedge clk);
      check(req, bus_rdata, counting ? 8'(pre + (k - 2) / 64) : pre);
    end
  endtask

  task automatic pulse();
    @(negedge clk); gate_in = 1'b1;
    repeat (3) @(negedge clk);
    gate_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg", v, 8'h00);
    end
    check("R1 ovf_o", {7'd0, ovf_o}, 8'h00);
    check("R1 irq_o", {7'd0, irq_o}, 8'h00);

    // R2, R4: gate high, tick every 64 clocks, first one a full period after enabling
    gate_in = 1'b1;
    sweep("R2", 8'h10, 8'h60, 1'b1, 200);
    // R4: disabled holds count
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    repeat (150) @(negedge clk);
    rd(2'd1, v);
    check("R4 disabled hold", v, 8'h13);

    // R3: gate low inhibits with polarity 0; polarity 1 counts while low
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    sweep("R3 low inhibits", 8'h20, 8'h60, 1'b0, 200);
    sweep("R3 inverted polarity", 8'h40, 8'h70, 1'b1, 200);
    gate_in = 1'b1;
    repeat (4) @(negedge clk);
    sweep("R3 high inhibits inverted", 8'h50, 8'h70, 1'b0, 140);

    // R9: count write coincides with the first tick
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h30);
    wr(2'd0, 8'h60);
    repeat (62) @(negedge clk);
    wr(2'd1, 8'h80);
    rd(2'd1, v);
    check("R9 write beats tick", v, 8'h80);

    // R5, R6, R8: preload 6 overflows after 250 ticks
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h06);
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h20);
    wr(2'd0, 8'h60);
    repeat (15999) @(negedge clk);
    check("R5 no overflow before tick 250", {7'd0, ovf_o}, 8'h00);
    check("R8 no irq before overflow", {7'd0, irq_o}, 8'h00);
    @(negedge clk);
    check("R5 overflow at tick 250", {7'd0, ovf_o}, 8'h01);
    check("R8 irq with mask set", {7'd0, irq_o}, 8'h01);
    rd(2'd1, v);
    check("R6 count wrapped to 0", v, 8'h00);
    rd(2'd2, v);
    check("R6 flag bit 5", v, 8'h20);

    // R7: write 0 keeps flag, write bit 5 clears
    wr(2'd2, 8'hDF);
    check("R7 write 0 keeps flag", {7'd0, ovf_o}, 8'h01);
    wr(2'd2, 8'h20);
    check("R7 write 1 clears flag", {7'd0, ovf_o}, 8'h00);
    check("R8 irq drops with flag", {7'd0, irq_o}, 8'h00);

    // R10: event mode, rising edges, wrap with mask off
    wr(2'd0, 8'h00);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h40);
    for (int p = 0; p < 3; p++) pulse();
    rd(2'd1, v);
    check("R10 rising edges", v, 8'h01);
    check("R6 event wrap sets flag", {7'd0, ovf_o}, 8'h01);
    check("R8 irq masked off", {7'd0, irq_o}, 8'h00);
    wr(2'd3, 8'h20);
    @(negedge clk);
    check("R8 irq after unmask", {7'd0, irq_o}, 8'h01);

    // R10: falling edges
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h50);
    for (int p = 0; p < 4; p++) pulse();
    rd(2'd1, v);
    check("R10 falling edges", v, 8'h04);

    // R11: readback masking
    wr(2'd0, 8'hFF);
    rd(2'd0, v);
    check("R11 control bits", v, 8'h70);
    wr(2'd3, 8'hFF);
    rd(2'd3, v);
    check("R11 mask bit", v, 8'h20);
    wr(2'd2, 8'hFF);
    rd(2'd2, v);
    check("R11 flag cleared reads 0", v, 8'h00);
    wr(2'd0, 8'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule